// File: doc/BRIEF.md
# Preloadable Interval Timer with Interrupt

An 8-bit up-counter that steps once per millisecond. The millisecond tick comes from an internal divide-by-1000 prescaler that counts pulses of a 1 MHz clock enable. Software uses three write-only registers on a simple bus: an address, a write strobe and 8-bit write data. One register loads a start value into the counter. One register holds an active-low run control. One register clears the interrupt. The bus has no read path.

When a tick takes the count to its all-ones value, the block sets a sticky pending flag. The following tick wraps the count to zero and counting goes on. The interrupt request to the CPU is the pending flag gated by an external timer-interrupt-enable input. The interval is set by the start value and runs from 1 to 256 ticks: a start value of FEh gives one tick and FFh gives 256 ticks.

Control is a two-state machine. HALT is the reset state, in which the prescaler is held at zero and the count is frozen. COUNT is the running state, in which ticks advance the count. Transition START (HALT to COUNT) fires on a control write with bit 0 = 0. Transition STOP (COUNT to HALT) fires on a control write with bit 0 = 1. A control write that matches the current state leaves the machine where it is.

Top module: `base_timer_irq`

## Requirements
- R1: After reset the machine is in HALT, the count is 00h and the pending flag is 0. The irq output stays 0 while no control write arrives, even with us_en pulsing. If the timer is then started without a start-value write, the first flag appears after 255 ticks.
- R2: In COUNT, the count advances once for every TICK_DIV cycles in which us_en is high. Cycles with us_en low do not advance the prescaler.
- R3: A write to address C0h loads bus_wdata into the count and restarts the prescaler from zero, whether the timer is running or halted. Counting continues upward from the loaded value.
- R4: Bit 0 of address C1h is the active-low, level-type run control. Writing 0 enters or stays in COUNT. Writing 1 enters or stays in HALT, where the count is held and the prescaler is cleared.
- R5: The tick that takes the count to FFh sets the pending flag. The following tick wraps the count to 00h, so the next flag comes 256 ticks later.
- R6: A write to address C2h with bit 0 = 1 clears the pending flag. A write to C2h with bit 0 = 0 leaves it unchanged. Otherwise the flag stays set.
- R7: irq equals the pending flag ANDed with irq_en. The flag is set even while irq_en is 0.
- R8: When a clear write and a flag-setting tick fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_en | input | 1 | 1 MHz clock-enable strobe that feeds the prescaler |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| irq_en | input | 1 | Timer interrupt enable (mask) |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The assertions take for granted that bus_addr, bus_we and bus_wdata are synchronous to clk and free of unknowns whenever bus_we is high. They also assume each write lasts exactly one cycle, so one register update is one event. The stimulus drives every input on the falling edge, keeps bus_we high for a single cycle per write and never overlaps two writes. The bench shortens the prescaler divisor so that intervals of a full 256 ticks fit the run, and it measures every interval as an edge count from the write that started it.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int unsigned BT_AW = 8;
    localparam int unsigned BT_DW = 8;

    localparam logic [BT_AW-1:0] BT_ADDR_LOAD = 8'hC0;
    localparam logic [BT_AW-1:0] BT_ADDR_CTL  = 8'hC1;
    localparam logic [BT_AW-1:0] BT_ADDR_ACK  = 8'hC2;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } bt_state_e;

endpackage

// File: rtl/bt_ctrl.sv
module bt_ctrl
    import bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BT_AW-1:0] bus_addr,
    input  logic             bus_we,
    input  logic             wbit0,
    output logic             run_o,
    output logic             ld_o,
    output logic             ack_o
);

    bt_state_e state_q, state_d;
    logic      ctl_wr;

    assign ctl_wr = bus_we && (bus_addr == BT_ADDR_CTL);
    assign ld_o   = bus_we && (bus_addr == BT_ADDR_LOAD);
    assign ack_o  = bus_we && (bus_addr == BT_ADDR_ACK) && wbit0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // transitions: START and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (ctl_wr && !wbit0) state_d = ST_COUNT;
            ST_COUNT: if (ctl_wr &&  wbit0) state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        run_o = 1'b0;
        unique case (state_q)
            ST_HALT:  run_o = 1'b0;
            ST_COUNT: run_o = 1'b1;
            default:  run_o = 1'b0;
        endcase
    end

    AST_START_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wbit0) |=> run_o); // R4
    AST_STOP_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wbit0) |=> !run_o); // R4
    AST_RUN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(run_o)); // R4

endmodule

// File: rtl/bt_prescale.sv
module bt_prescale #(
    parameter int unsigned TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    input  logic us_en,
    output logic tick_o
);

    localparam int unsigned PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_q;
    logic          at_last;

    assign at_last = (pre_q == LAST);
    assign tick_o  = run_i && !restart_i && us_en && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run_i || restart_i) begin
            pre_q <= '0;
        end else if (us_en) begin
            pre_q <= at_last ? '0 : pre_q + 1'b1;
        end
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST); // R2
    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && !us_en) |=> $stable(pre_q)); // R2
    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i || !run_i) |=> (pre_q == '0)); // R3

endmodule

// File: rtl/bt_count.sv
module bt_count #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val,
    output logic             top_o
);

    localparam logic [CNT_W-1:0] NEAR_TOP = {{(CNT_W-1){1'b1}}, 1'b0};

    logic [CNT_W-1:0] cnt_q;

    assign top_o = tick_i && !ld_i && (cnt_q == NEAR_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (ld_i)   cnt_q <= ld_val;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_q == $past(ld_val))); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ld_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !ld_i) |=> $stable(cnt_q)); // R4
    AST_CNT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        top_o |=> (&cnt_q)); // R5

endmodule

// File: rtl/bt_pend.sv
module bt_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend_o <= 1'b0;
        else if (set_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o); // R8
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o); // R6

endmodule

// File: rtl/base_timer_irq.sv
module base_timer_irq
    import bt_pkg::*;
#(
    parameter int unsigned TICK_DIV = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_en,
    input  logic [BT_AW-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [BT_DW-1:0] bus_wdata,
    input  logic             irq_en,
    output logic             irq
);

    logic run, ld, ack, tick, top, pend;

    bt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .wbit0    (bus_wdata[0]),
        .run_o    (run),
        .ld_o     (ld),
        .ack_o    (ack)
    );

    bt_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (ld),
        .us_en     (us_en),
        .tick_o    (tick)
    );

    bt_count #(.CNT_W(BT_DW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .ld_i   (ld),
        .ld_val (bus_wdata),
        .top_o  (top)
    );

    bt_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (top),
        .clr_i  (ack),
        .pend_o (pend)
    );

    assign irq = pend && irq_en;

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run); // R2
    AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R7

endmodule

// File: tb/base_timer_irq_tb_top.sv
module base_timer_irq_tb_top;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_en = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       irq_en = 1'b1;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    base_timer_irq #(.TICK_DIV(DIV)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_en     (us_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .irq_en    (irq_en),
        .irq       (irq)
    );

    localparam logic [7:0] VEC_PRE [4] = '{8'hFE, 8'hF0, 8'h00, 8'hFF};
    localparam int         VEC_TCK [4] = '{1, 15, 255, 256};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        us_en = 1'b1;
        irq_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = -1;
        for (int i = 1; i <= 3000; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (irq) begin
                n = i;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;

        // interval table: preload then start, edges to irq
        for (int v = 0; v < 4; v++) begin
            do_reset();
            wr(8'hC0, VEC_PRE[v]);
            wr(8'hC1, 8'h00);
            wait_irq(n);
            chk(n == VEC_TCK[v] * DIV, "R3/R5 interval", n, VEC_TCK[v] * DIV);
        end

        // R5 wrap: after flag at FFh, clear one edge later, next flag 256 ticks on
        wr(8'hC2, 8'h01);
        chk(irq == 1'b0, "R6 clear", irq, 0);
        wait_irq(n);
        chk(n == 256 * DIV - 1, "R5 wrap", n, 256 * DIV - 1);

        // R6: bit0 = 0 has no effect, bit0 = 1 clears
        wr(8'hC2, 8'h00);
        chk(irq == 1'b1, "R6 ignore0", irq, 1);
        wr(8'hC2, 8'hFE);
        chk(irq == 1'b1, "R6 ignoreFE", irq, 1);
        wr(8'hC2, 8'h01);
        chk(irq == 1'b0, "R6 clear1", irq, 0);

        // R1: reset state, disabled and count zero
        do_reset();
        chk(irq == 1'b0, "R1 reset irq", irq, 0);
        idle(50);
        chk(irq == 1'b0, "R1 halted", irq, 0);
        wr(8'hC1, 8'h00);
        wait_irq(n);
        chk(n == 255 * DIV, "R1 from zero", n, 255 * DIV);

        // R7: flag sets while masked
        do_reset();
        irq_en = 1'b0;
        wr(8'hC0, 8'hFE);
        wr(8'hC1, 8'h00);
        idle(10);
        chk(irq == 1'b0, "R7 masked", irq, 0);
        irq_en = 1'b1;
        #1;
        chk(irq == 1'b1, "R7 unmasked", irq, 1);

        // R4: stop holds the count, restart continues
        do_reset();
        wr(8'hC0, 8'hFD);
        wr(8'hC1, 8'h00);
        idle(5);
        wr(8'hC1, 8'h01);
        idle(40);
        chk(irq == 1'b0, "R4 stopped", irq, 0);
        wr(8'hC1, 8'h00);
        wait_irq(n);
        chk(n == DIV, "R4 resume", n, DIV);

        // R3: preload while running restarts the prescaler
        do_reset();
        wr(8'hC0, 8'hF0);
        wr(8'hC1, 8'h00);
        idle(10);
        wr(8'hC0, 8'hFE);
        wait_irq(n);
        chk(n == DIV, "R3 reload", n, DIV);

        // R2: no progress without us_en
        do_reset();
        us_en = 1'b0;
        wr(8'hC0, 8'hFE);
        wr(8'hC1, 8'h00);
        idle(30);
        chk(irq == 1'b0, "R2 no enable", irq, 0);
        us_en = 1'b1;
        wait_irq(n);
        chk(n == DIV, "R2 tick", n, DIV);

        // R8: clear in the overflow cycle, set wins
        do_reset();
        wr(8'hC0, 8'hFE);
        wr(8'hC1, 8'h00);
        idle(DIV - 1);
        wr(8'hC2, 8'h01);
        chk(irq == 1'b1, "R8 set wins", irq, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule